// File: doc/BRIEF.md
# Host-to-CPU Tagged Mailbox Port

This block is a one-way mailbox that a host computer uses to pass bytes to a local processor across a strobed parallel bus. For each transfer the host first stores a small tag that classifies the coming byte, then the byte itself. The tag marks the byte as a command or as data, and as meant for the video side or the disk side. Storing the byte marks the mailbox full. The full state shows to the host as an active-low buffer-full line and to the local processor as an interrupt.

The local processor reads the latched byte and tag from dedicated outputs. It then drives its acknowledge line low, which empties the mailbox and clears the interrupt. The host polls a status word to learn when it may send again. The low three bits of that word read zero whenever the unit is out of reset, which the host treats as the sign that the unit is operable. A byte sent while the mailbox is still full is dropped, and the loss is recorded in a sticky overrun bit.

Top module: `mbx_port`

## Requirements
- R1: On reset, obfN is 1, localInt is 0, mailByte and mailTag are 0, and overrunFlag is 0.
- R2: A host write to address 1 while the mailbox is empty stores the low 4 data bits in mailTag on the clock edge where the write is first sampled. The upper data bits are discarded.
- R3: A host write to address 0 while the mailbox is empty stores the byte in mailByte and drives obfN low on the clock edge where the write is first sampled.
- R4: localInt is 1 exactly when obfN is 0.
- R5: localAckN sampled low while the mailbox is full sets obfN to 1 and localInt to 0 at that edge. Sampled low while the mailbox is empty, it changes nothing.
- R6: A write strobe held low for several cycles counts as one write. It takes effect only on the first sampled cycle.
- R7: A host write to address 0 while the mailbox is full leaves mailByte unchanged and sets overrunFlag. overrunFlag then stays 1 until reset.
- R8: A host write to address 1 while the mailbox is full leaves mailTag unchanged and does not set overrunFlag.
- R9: While hostCsN and hostRdN are both low, hostDoe is 1 and hostDout returns a value chosen by address. Address 0 returns the byte. Address 1 returns the tag zero-extended. Address 2 returns the status word: bit 7 is obfN, bit 6 is overrunFlag, and bits 5 to 0 are 0. Address 3 returns 0. At all other times hostDoe is 0 and hostDout is 0.
- R10: While hostCsN is high, the read and write strobes have no effect.
- R11: While the mailbox stays full, mailByte and mailTag do not change.
- R12: If an acknowledge and a byte write meet on the same edge while the mailbox is full, the mailbox empties, mailByte keeps its old value, and overrunFlag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostCsN | input | 1 | Host chip select, active low |
| hostA | input | 2 | Host port address |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostDin | input | 8 | Host write data |
| hostDout | output | 8 | Host read data |
| hostDoe | output | 1 | Host read data valid / bus drive enable |
| localAckN | input | 1 | Local processor acknowledge, active low |
| obfN | output | 1 | Buffer full, active low |
| localInt | output | 1 | Interrupt to the local processor |
| mailByte | output | 8 | Latched byte |
| mailTag | output | 4 | Latched tag |
| overrunFlag | output | 1 | Sticky lost-byte flag |

## Verification
The hardest cases to reach are the ones where two events meet on the same clock edge. One is an acknowledge that lands on the same edge as a second byte write. The other is a write strobe held low across several edges while the mailbox changes from empty to full beneath it. The stimulus reaches both cases by holding the strobe low for several cycles and by overlapping a timed acknowledge pulse with a write. A behavioural model run in parallel decides every cycle which event wins, and the design's outputs are compared against it on each clock. Reset is applied again partway through the run to show that the sticky overrun bit clears only there.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef struct packed {
    logic loadByte;
    logic loadTag;
  } mbxStrobeT;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int BYTE_ADDR = 0,
  parameter int TAG_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ackN,
  output mbxStrobeT         strobe,
  output logic              bufFull,
  output logic              cpuInt,
  output logic              overrun
);
  localparam logic [ADDR_W-1:0] BYTE_SEL = ADDR_W'(BYTE_ADDR);
  localparam logic [ADDR_W-1:0] TAG_SEL  = ADDR_W'(TAG_ADDR);

  logic wrAct, wrPrev, wrEvent, hitByte, hitTag, ackTake;

  assign wrAct   = !csN && !wrN;
  assign wrEvent = wrAct && !wrPrev;
  assign hitByte = wrEvent && (addr == BYTE_SEL);
  assign hitTag  = wrEvent && (addr == TAG_SEL);
  assign ackTake = !ackN && bufFull;

  always_comb begin
    strobe.loadByte = hitByte && !bufFull;
    strobe.loadTag  = hitTag && !bufFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev  <= 1'b0;
      bufFull <= 1'b0;
      cpuInt  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      wrPrev <= wrAct;
      if (strobe.loadByte) begin
        bufFull <= 1'b1;
        cpuInt  <= 1'b1;
      end else if (ackTake) begin
        bufFull <= 1'b0;
        cpuInt  <= 1'b0;
      end
      if (hitByte && bufFull) overrun <= 1'b1;
    end
  end

  a_r4_int_matches_full: assert property (@(posedge clk) disable iff (!rstN)
    cpuInt == bufFull);
  a_r5_ack_drains: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !ackN) |=> (!bufFull && !cpuInt));
  a_r3_byte_fills: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !wrN && !wrPrev && addr == BYTE_SEL && !bufFull) |=> bufFull);
  a_r6_single_event: assert property (@(posedge clk) disable iff (!rstN)
    wrEvent |=> !wrEvent);
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
endmodule

// File: rtl/mbx_dpath.sv
module mbx_dpath
  import mbx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int TAG_W     = 4,
  parameter int ADDR_W    = 2,
  parameter int BYTE_ADDR = 0,
  parameter int TAG_ADDR  = 1,
  parameter int STAT_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbxStrobeT         strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              csN,
  input  logic              rdN,
  input  logic              bufFull,
  input  logic              overrun,
  output logic [DATA_W-1:0] byteQ,
  output logic [TAG_W-1:0]  tagQ,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  localparam logic [ADDR_W-1:0] BYTE_SEL = ADDR_W'(BYTE_ADDR);
  localparam logic [ADDR_W-1:0] TAG_SEL  = ADDR_W'(TAG_ADDR);
  localparam logic [ADDR_W-1:0] STAT_SEL = ADDR_W'(STAT_ADDR);
  localparam int PAD_W  = DATA_W - TAG_W;
  localparam int ZERO_W = DATA_W - 2;

  logic [DATA_W-1:0] statusWord, tagWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteQ <= '0;
      tagQ  <= '0;
    end else begin
      if (strobe.loadByte) byteQ <= dataIn;
      if (strobe.loadTag)  tagQ  <= dataIn[TAG_W-1:0];
    end
  end

  assign statusWord = {!bufFull, overrun, {ZERO_W{1'b0}}};
  assign tagWord    = {{PAD_W{1'b0}}, tagQ};
  assign dataOe     = !csN && !rdN;

  always_comb begin
    dataOut = '0;
    if (dataOe) begin
      if (addr == BYTE_SEL)      dataOut = byteQ;
      else if (addr == TAG_SEL)  dataOut = tagWord;
      else if (addr == STAT_SEL) dataOut = statusWord;
    end
  end

  a_r11_hold_while_full: assert property (@(posedge clk) disable iff (!rstN)
    bufFull |=> (!bufFull || ($stable(byteQ) && $stable(tagQ))));
  a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    (csN || rdN) |-> (dataOut == '0));
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TAG_W  = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic [ADDR_W-1:0] hostA,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [DATA_W-1:0] hostDin,
  output logic [DATA_W-1:0] hostDout,
  output logic              hostDoe,
  input  logic              localAckN,
  output logic              obfN,
  output logic              localInt,
  output logic [DATA_W-1:0] mailByte,
  output logic [TAG_W-1:0]  mailTag,
  output logic              overrunFlag
);
  mbxStrobeT strobe;
  logic bufFull;

  mbx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(hostCsN), .wrN(hostWrN), .addr(hostA),
    .ackN(localAckN), .strobe(strobe), .bufFull(bufFull),
    .cpuInt(localInt), .overrun(overrunFlag)
  );

  mbx_dpath #(.DATA_W(DATA_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(hostDin), .addr(hostA),
    .csN(hostCsN), .rdN(hostRdN), .bufFull(bufFull), .overrun(overrunFlag),
    .byteQ(mailByte), .tagQ(mailTag), .dataOut(hostDout), .dataOe(hostDoe)
  );

  assign obfN = !bufFull;
endmodule

// File: tb/test_mbx_port.sv
`timescale 1ns/100ps
module test_mbx_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCsN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1, localAckN = 1'b1;
  logic [1:0] hostA = 2'd0;
  logic [7:0] hostDin = 8'h00;
  logic [7:0] hostDout, mailByte;
  logic [3:0] mailTag;
  logic hostDoe, obfN, localInt, overrunFlag;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  // behavioural reference state
  int mFull = 0, mInt = 0, mOvr = 0, mPrev = 0;
  int mByte = 0, mTag = 0;

  always #2.5 clk = ~clk;

  mbx_port i_mbx_port (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostA(hostA),
    .hostRdN(hostRdN), .hostWrN(hostWrN), .hostDin(hostDin),
    .hostDout(hostDout), .hostDoe(hostDoe), .localAckN(localAckN),
    .obfN(obfN), .localInt(localInt), .mailByte(mailByte),
    .mailTag(mailTag), .overrunFlag(overrunFlag)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFull <= 0; mInt <= 0; mOvr <= 0; mPrev <= 0; mByte <= 0; mTag <= 0;
    end else begin
      int act, ev;
      act = (hostCsN == 1'b0 && hostWrN == 1'b0) ? 1 : 0;
      ev  = (act == 1 && mPrev == 0) ? 1 : 0;
      mPrev <= act;
      if (ev == 1 && hostA == 2'd0) begin
        if (mFull == 0) begin
          mByte <= hostDin; mFull <= 1; mInt <= 1;
        end else begin
          mOvr <= 1;
        end
      end
      if (ev == 1 && hostA == 2'd1 && mFull == 0) mTag <= hostDin % 16;
      if (mFull == 1 && localAckN == 1'b0) begin
        mFull <= 0; mInt <= 0;
      end
    end
  end

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check(obfN, 1 - mFull, "R3 obfN");
      check(localInt, mInt, "R4 localInt");
      check(mailByte, mByte, "R7 mailByte");
      check(mailTag, mTag, "R2 mailTag");
      check(overrunFlag, mOvr, "R7 overrunFlag");
    end
  end

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d, input int hold, input logic cs);
    @(negedge clk);
    hostCsN = cs; hostWrN = 1'b0; hostA = a; hostDin = d;
    repeat (hold) @(negedge clk);
    hostCsN = 1'b1; hostWrN = 1'b1;
  endtask

  task automatic hostRead(input logic [1:0] a, input int exp, input string req);
    @(negedge clk);
    hostCsN = 1'b0; hostRdN = 1'b0; hostA = a;
    #1;
    check(hostDoe, 1, req);
    check(hostDout, exp, req);
    @(negedge clk);
    hostCsN = 1'b1; hostRdN = 1'b1;
    #1;
    check(hostDoe, 0, "R9 idle oe");
    check(hostDout, 0, "R9 idle data");
  endtask

  task automatic ackPulse(input int len);
    @(negedge clk);
    localAckN = 1'b0;
    repeat (len) @(negedge clk);
    localAckN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(obfN, 1, "R1 reset obfN");
    check(localInt, 0, "R1 reset int");
    check(overrunFlag, 0, "R1 reset overrun");
    rstN = 1'b1;
    hostRead(2'd2, 8'h80, "R9 status after reset");
    hostWrite(2'd1, 8'hF5, 1, 1'b0);            // R2 upper bits dropped
    hostRead(2'd1, 8'h05, "R2 tag readback");
    hostWrite(2'd0, 8'hA7, 4, 1'b0);            // R6 held strobe, one event
    @(negedge clk); #1;
    check(obfN, 0, "R3 full after byte");
    check(overrunFlag, 0, "R6 held strobe no overrun");
    hostRead(2'd0, 8'hA7, "R3 byte readback");
    hostRead(2'd2, 8'h00, "R9 status full");
    hostRead(2'd3, 8'h00, "R9 unused address");
    hostWrite(2'd1, 8'h03, 1, 1'b0);            // R8
    @(negedge clk); #1;
    check(mailTag, 5, "R8 tag kept while full");
    check(overrunFlag, 0, "R8 no overrun");
    ackPulse(1);
    @(negedge clk); #1;
    check(obfN, 1, "R5 ack empties");
    check(localInt, 0, "R5 int cleared");
    ackPulse(2);                                 // R5 ack while empty
    hostRead(2'd2, 8'h80, "R5 no change on idle ack");
    hostWrite(2'd0, 8'h99, 1, 1'b1);            // R10 deselected
    @(negedge clk); #1;
    check(obfN, 1, "R10 deselected write");
    check(mailByte, 8'hA7, "R10 byte unchanged");
    hostWrite(2'd1, 8'h0C, 1, 1'b0);
    hostWrite(2'd0, 8'h3C, 1, 1'b0);
    hostWrite(2'd0, 8'h11, 1, 1'b0);            // R7 overrun
    @(negedge clk); #1;
    check(mailByte, 8'h3C, "R7 byte kept");
    check(overrunFlag, 1, "R7 overrun set");
    hostRead(2'd2, 8'h40, "R9 status overrun full");
    // R12 ack and write meet on the same edge
    @(negedge clk);
    localAckN = 1'b0; hostCsN = 1'b0; hostWrN = 1'b0; hostA = 2'd0; hostDin = 8'h55;
    @(negedge clk);
    localAckN = 1'b1; hostCsN = 1'b1; hostWrN = 1'b1;
    #1;
    check(obfN, 1, "R12 emptied");
    check(mailByte, 8'h3C, "R12 byte kept");
    check(overrunFlag, 1, "R12 overrun");
    hostWrite(2'd0, 8'h66, 1, 1'b0);
    ackPulse(1);
    check(overrunFlag, 1, "R7 sticky");
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk); #1;
    check(overrunFlag, 0, "R1 reset clears overrun");
    check(mailByte, 0, "R1 reset byte");
    check(mailTag, 0, "R1 reset tag");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule